// File: doc/BRIEF.md
# Audio master clock ratio generator

This block derives the master clock for an external audio codec, together with the pacing strobes for the serial bit clock and the per-sample frame clock. It uses one oversampled clock, which is also its own register clock. That clock runs at twice the selected base rate. In the 512x family it is 1024 times the sample rate. In the 384x family it is 768 times the sample rate. A toggling register can therefore reproduce the full base rate on the master-clock pin.

A family-select bit chooses the base. A 3-bit ratio code divides the base by a power of two to form the master clock. A wide-word bit selects 48 bit-clock strobes per sample instead of 64. The strobes are spread evenly across the sample frame by a fractional accumulator. A sample frame is 1024 cycles in the 512x family and 768 cycles in the 384x family.

Whenever the run input is low, every counter is held at zero. The first output edge after run rises is therefore fixed. Configuration inputs may change only while run is low.

Top module: `audio_mclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mclk_out`, `bit_stb`, `frame_stb` and `cfg_err` are all 0.
- R2: When `run` is 0 at a rising clock edge, `mclk_out`, `bit_stb` and `frame_stb` are 0 after that edge. This holds for any configuration.
- R3: With `base_sel` = 0 (512x family, 1024 clock cycles per sample), codes 0, 1, 2, 3 and 4 give a `mclk_out` period of 2, 4, 8, 16 and 32 clock cycles. These correspond to 512x, 256x, 128x, 64x and 32x the sample rate.
- R4: With `base_sel` = 1 (384x family, 768 clock cycles per sample), codes 0, 1, 2 and 3 give a `mclk_out` period of 2, 4, 8 and 16 clock cycles. These correspond to 384x, 192x, 96x and 48x the sample rate.
- R5: A code above 4 with `base_sel` = 0, or above 3 with `base_sel` = 1, is illegal. One cycle later `cfg_err` is 1 and `mclk_out` is held at 0, while the strobes keep running. A legal code gives `cfg_err` = 0 one cycle later.
- R6: Number the rising edges from 0, starting with the first edge at which `run` is sampled 1 after being 0. With a legal code c, `mclk_out` after edge i equals bit c of (i+1).
- R7: `frame_stb` is 1 after edge i exactly when (i+1) is a multiple of F, with F = 1024 for `base_sel` = 0 and F = 768 for `base_sel` = 1.
- R8: With `wide_en` = 0, B = 64. `bit_stb` is 1 after edge i exactly when floor((i+1)·B/F) > floor(i·B/F). This gives 64 strobes per frame, the last one coinciding with `frame_stb`.
- R9: With `wide_en` = 1, the rule of R8 applies with B = 48, giving 48 strobes per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampled clock, twice the base rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables all outputs; when low, counters restart from zero |
| base_sel | input | 1 | Base family: 0 = 512x, 1 = 384x |
| mult_code | input | 3 | Power-of-two divide code for the master clock |
| wide_en | input | 1 | 1 = 48 bit strobes per sample, 0 = 64 |
| mclk_out | output | 1 | Codec master clock |
| bit_stb | output | 1 | One-cycle enable for the serial bit clock |
| frame_stb | output | 1 | One-cycle enable for the frame (left/right) clock, once per sample |
| cfg_err | output | 1 | Illegal family/code pairing flag |

## Verification
The inline assertions check the following on every cycle:
- outputs are silenced while run is low;
- an illegal code forces the error flag and a silent master clock;
- the first master-clock value after run rises is correct;
- no two bit strobes come back to back;
- every frame holds exactly the expected number of bit strobes.

The exact phase of each master-clock division, the position of every bit strobe inside the frame, and the frame length of each family can only be shown by the bench scenarios. These scenarios run full frames in both families, in both strobe modes, and across a stop-and-restart of run.

// File: rtl/audio_mclk_pkg.sv
package audio_mclk_pkg;

   typedef enum logic {
      FAMILY_512 = 1'b0,
      FAMILY_384 = 1'b1
   } family_e;

   // Largest legal ratio code for a family, given the two limits.
   function automatic int max_code(input logic fam, input int max_hi, input int max_lo);
      return fam ? max_lo : max_hi;
   endfunction

endpackage

// File: rtl/amg_mclk_div.sv
module amg_mclk_div #(
   parameter int CODE_W = 3,
   parameter int TAP_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              legal,
   input  logic [CODE_W-1:0] code,
   output logic              mclk
);
   localparam int NCODE = 1 << CODE_W;

   logic [TAP_W-1:0] cnt_q;
   logic [TAP_W-1:0] cnt_nxt;
   logic [NCODE-1:0] tap;

   generate
      if (TAP_W > NCODE) begin : g_bad_taps
         $error("amg_mclk_div: TAP_W exceeds the code range");
      end
      for (genvar k = 0; k < NCODE; k++) begin : g_tap
         if (k < TAP_W) begin : g_live
            assign tap[k] = cnt_nxt[k];
         end else begin : g_dead
            assign tap[k] = 1'b0;
         end
      end
   endgenerate

   assign cnt_nxt = run ? cnt_q + 1'b1 : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mclk  <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         mclk  <= run && legal && tap[code];
      end
   end
endmodule

// File: rtl/amg_frame_cnt.sv
module amg_frame_cnt #(
   parameter int FRAME_HI = 1024,
   parameter int FRAME_LO = 768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic base_sel,
   output logic frame_stb
);
   localparam int FW = $clog2(FRAME_HI);

   logic [FW-1:0] fcnt_q;
   logic [FW-1:0] last;
   logic          wrap;

   generate
      if (FRAME_LO > FRAME_HI || FRAME_LO < 2) begin : g_bad_frame
         $error("amg_frame_cnt: frame lengths out of range");
      end
   endgenerate

   assign last = base_sel ? FW'(FRAME_LO - 1) : FW'(FRAME_HI - 1);
   assign wrap = (fcnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q    <= '0;
         frame_stb <= 1'b0;
      end else if (!run) begin
         fcnt_q    <= '0;
         frame_stb <= 1'b0;
      end else begin
         fcnt_q    <= wrap ? '0 : fcnt_q + 1'b1;
         frame_stb <= wrap;
      end
   end
endmodule

// File: rtl/amg_bit_pacer.sv
module amg_bit_pacer #(
   parameter int FRAME_HI  = 1024,
   parameter int FRAME_LO  = 768,
   parameter int BITS_STD  = 64,
   parameter int BITS_WIDE = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic base_sel,
   input  logic wide_en,
   input  logic frame_stb,
   output logic bit_stb
);
   localparam int AW = $clog2(FRAME_HI + BITS_STD + 1);
   localparam int CW = $clog2(BITS_STD + 1) + 1;

   logic [AW-1:0] acc_q;
   logic [AW-1:0] flen;
   logic [AW-1:0] blen;
   logic [AW-1:0] sum;
   logic          hit;

   generate
      if (2 * BITS_STD > FRAME_LO || BITS_WIDE > BITS_STD) begin : g_bad_bits
         $error("amg_bit_pacer: strobe counts too high for the frame");
      end
   endgenerate

   assign flen = base_sel ? AW'(FRAME_LO) : AW'(FRAME_HI);
   assign blen = wide_en ? AW'(BITS_WIDE) : AW'(BITS_STD);
   assign sum  = acc_q + blen;
   assign hit  = (sum >= flen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         bit_stb <= 1'b0;
      end else if (!run) begin
         acc_q   <= '0;
         bit_stb <= 1'b0;
      end else begin
         acc_q   <= hit ? sum - flen : sum;
         bit_stb <= hit;
      end
   end

   // Checker: strobes counted within each frame.
   logic [CW-1:0] seen_q;
   logic [CW-1:0] want;
   assign want = wide_en ? CW'(BITS_WIDE) : CW'(BITS_STD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              seen_q <= '0;
      else if (!run)           seen_q <= '0;
      else if (frame_stb)      seen_q <= '0;
      else if (bit_stb)        seen_q <= seen_q + 1'b1;
   end

   // R8 and R9: strobes per frame
   assert_bits_per_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && frame_stb) |-> (seen_q + CW'(bit_stb)) == want);

   assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);
endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen
   import audio_mclk_pkg::*;
#(
   parameter int CODE_W      = 3,
   parameter int MAX_CODE_HI = 4,
   parameter int MAX_CODE_LO = 3,
   parameter int BASE_HI     = 512,
   parameter int BASE_LO     = 384,
   parameter int BITS_STD    = 64,
   parameter int BITS_WIDE   = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              base_sel,
   input  logic [CODE_W-1:0] mult_code,
   input  logic              wide_en,
   output logic              mclk_out,
   output logic              bit_stb,
   output logic              frame_stb,
   output logic              cfg_err
);
   localparam int FRAME_HI = 2 * BASE_HI;
   localparam int FRAME_LO = 2 * BASE_LO;
   localparam int TAP_W    = MAX_CODE_HI + 1;

   generate
      if (MAX_CODE_LO > MAX_CODE_HI || MAX_CODE_HI >= (1 << CODE_W)) begin : g_bad_codes
         $error("audio_mclk_gen: code limits inconsistent with CODE_W");
      end
   endgenerate

   logic cfg_ok;
   assign cfg_ok = (int'(mult_code) <= max_code(base_sel, MAX_CODE_HI, MAX_CODE_LO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err <= 1'b0;
      else        cfg_err <= !cfg_ok;
   end

   amg_mclk_div #(.CODE_W(CODE_W), .TAP_W(TAP_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .legal(cfg_ok),
      .code(mult_code), .mclk(mclk_out)
   );

   amg_frame_cnt #(.FRAME_HI(FRAME_HI), .FRAME_LO(FRAME_LO)) u_frame (
      .clk(clk), .rst_n(rst_n), .run(run), .base_sel(base_sel),
      .frame_stb(frame_stb)
   );

   amg_bit_pacer #(.FRAME_HI(FRAME_HI), .FRAME_LO(FRAME_LO),
                   .BITS_STD(BITS_STD), .BITS_WIDE(BITS_WIDE)) u_pace (
      .clk(clk), .rst_n(rst_n), .run(run), .base_sel(base_sel),
      .wide_en(wide_en), .frame_stb(frame_stb), .bit_stb(bit_stb)
   );

   assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!mclk_out && !bit_stb && !frame_stb));

   assert_cfg_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ok |=> (cfg_err && !mclk_out));

   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run) && cfg_ok) |=> (mclk_out == ($past(mult_code) == '0)));
endmodule

// File: tb/audio_mclk_gen_tb.sv
module audio_mclk_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run = 1'b0;
   logic       base_sel = 1'b0;
   logic [2:0] mult_code = 3'd0;
   logic       wide_en = 1'b0;
   logic       mclk_out, bit_stb, frame_stb, cfg_err;

   int checks = 0;
   int failures = 0;
   int fail_prints = 0;

   always #5 clk = ~clk;

   audio_mclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .run(run), .base_sel(base_sel),
      .mult_code(mult_code), .wide_en(wide_en), .mclk_out(mclk_out),
      .bit_stb(bit_stb), .frame_stb(frame_stb), .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         if (fail_prints < 40) begin
            fail_prints++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
         end
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      run = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 mclk in reset", mclk_out, 0);
      chk("R1 bit_stb in reset", bit_stb, 0);
      chk("R1 frame_stb in reset", frame_stb, 0);
      chk("R1 cfg_err in reset", cfg_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", {mclk_out, bit_stb, frame_stb, cfg_err}, 0);
   endtask

   task automatic t_idle();
      run = 1'b0;
      base_sel = 1'b0;
      mult_code = 3'd0;
      wide_en = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk("R2 idle outputs", {mclk_out, bit_stb, frame_stb}, 0);
      end
   endtask

   // Run one configuration from a fresh start and check each cycle.
   task automatic t_run(input string tag, input logic b, input int code,
                        input logic w, input int ncyc);
      int frame = b ? 768 : 1024;
      int bits  = w ? 48 : 64;
      int maxc  = b ? 3 : 4;
      bit legal = (code <= maxc);
      int nbit  = 0;
      int nfrm  = 0;
      run = 1'b0;
      base_sel = b;
      mult_code = 3'(code);
      wide_en = w;
      @(negedge clk);
      @(negedge clk);
      chk({tag, " R5 cfg_err"}, cfg_err, legal ? 0 : 1);
      run = 1'b1;
      for (int i = 0; i < ncyc; i++) begin
         int em;
         int eb;
         int ef;
         @(negedge clk);
         em = legal ? (((i + 1) >> code) & 1) : 0;
         eb = (((i + 1) * bits) / frame > (i * bits) / frame) ? 1 : 0;
         ef = (((i + 1) % frame) == 0) ? 1 : 0;
         chk({tag, " R6 mclk phase"}, mclk_out, em);
         chk({tag, " R8 bit_stb position"}, bit_stb, eb);
         chk({tag, " R7 frame_stb position"}, frame_stb, ef);
         if (!legal) chk({tag, " R5 err held"}, cfg_err, 1);
         nbit += bit_stb;
         nfrm += frame_stb;
      end
      chk({tag, " R9 bit strobe total"}, nbit, (ncyc * bits) / frame);
      chk({tag, " R7 frame total"}, nfrm, ncyc / frame);
      run = 1'b0;
      @(negedge clk);
      chk({tag, " R2 stop silences"}, {mclk_out, bit_stb, frame_stb}, 0);
   endtask

   task automatic t_period(input string tag, input logic b, input int code, input int per);
      int last_rise = -1;
      int prev = 0;
      int seen = 0;
      run = 1'b0;
      base_sel = b;
      mult_code = 3'(code);
      wide_en = 1'b0;
      @(negedge clk);
      run = 1'b1;
      for (int i = 0; i < 8 * per + 4; i++) begin
         @(negedge clk);
         if (mclk_out && !prev) begin
            if (last_rise >= 0) begin
               chk(tag, i - last_rise, per);
               seen++;
            end
            last_rise = i;
         end
         prev = mclk_out;
      end
      chk({tag, " rising edges seen"}, (seen >= 6) ? 1 : 0, 1);
      run = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_restart();
      base_sel = 1'b0;
      mult_code = 3'd2;
      wide_en = 1'b0;
      run = 1'b0;
      @(negedge clk);
      run = 1'b1;
      repeat (37) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk("R2 mid-run stop", {mclk_out, bit_stb, frame_stb}, 0);
      repeat (5) @(negedge clk);
      run = 1'b1;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         chk("R6 restart mclk phase", mclk_out, ((i + 1) >> 2) & 1);
         chk("R8 restart bit_stb", bit_stb, (((i + 1) % 16) == 0) ? 1 : 0);
      end
      run = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_period("R3 base512 code0 period", 1'b0, 0, 2);
      t_period("R3 base512 code4 period", 1'b0, 4, 32);
      t_period("R4 base384 code1 period", 1'b1, 1, 4);
      t_period("R4 base384 code3 period", 1'b1, 3, 16);
      t_run("R3 b512 c0 std", 1'b0, 0, 1'b0, 2100);
      t_run("R3 b512 c4 std", 1'b0, 4, 1'b0, 1100);
      t_run("R9 b512 c2 wide", 1'b0, 2, 1'b1, 2100);
      t_run("R4 b384 c0 std", 1'b1, 0, 1'b0, 1600);
      t_run("R4 b384 c3 wide", 1'b1, 3, 1'b1, 1600);
      t_run("R5 b384 c4 illegal", 1'b1, 4, 1'b0, 800);
      t_run("R5 b512 c6 illegal", 1'b0, 6, 1'b1, 1100);
      t_restart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule